// File: doc/BRIEF.md
# Segment Selector and Linear Address Former

This block picks the segment register that supplies the base of a data access and turns a segment and offset pair into a real-mode linear address. The segment value is shifted left by four and added to the offset. While an instruction is being decoded, the block records two kinds of events. Segment override prefixes become a one-hot set of override bits. An address-decode event sets a stack-default bit, which asks for SS in place of DS when no override is present. An end-of-instruction pulse clears this state, so a prefix applies only to the instruction it precedes.

The selection has a fixed priority:

1. An absolute-access request bypasses selection and uses the segment value it supplies.
2. Exactly one override uses its named segment.
3. With no override, the stack-default bit chooses between SS and DS.

More than one override at the time of an access is a fatal condition. The base becomes zero and a sticky halt flag is raised. A prefix that carries an illegal segment code also raises the halt flag.

Top module: `seg_linear_former`

## Requirements
- R1: After reset, no override or stack-default state is held, `halt` is 0, and an access uses DS.
- R2: With no override and the stack-default bit clear, the base is DS.
- R3: With no override and the stack-default bit set by `stk_dflt_set`, the base is SS.
- R4: A prefix code selects a segment as follows: 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS, 5 = GS. A single recorded override uses its named segment, and the stack-default bit has no effect.
- R5: If two or more different overrides are held at a non-absolute access, `lin_addr` equals the offset (zero base), and `halt` is 1 from the next cycle.
- R6: `lin_addr` = segment × 16 + offset. It is computed in 33 bits with no wrap, so segment 0xFFFF with offset 0xFFFFFFFF gives 0x1000FFFEF.
- R7: `insn_end` clears all override bits and the stack-default bit. A prefix or stack-default event in the same cycle is kept for the next instruction.
- R8: With `abs_mode` set, the base is `abs_seg`, whatever the override state. Multiple overrides then raise no halt.
- R9: A prefix with code 6 or 7 sets `halt` from the next cycle and records no override.
- R10: `halt` stays 1 until reset, through later instructions and clears.
- R11: Prefix and stack-default events take effect from the cycle after they are presented. An access in the same cycle uses the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfx_valid | input | 1 | A segment override prefix is seen this cycle |
| pfx_code | input | 3 | Segment code of the prefix (0..5 legal) |
| stk_dflt_set | input | 1 | Address decode requests SS as the default |
| insn_end | input | 1 | End of instruction: clear the prefix state |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| seg_fs | input | 16 | FS value |
| seg_gs | input | 16 | GS value |
| acc_valid | input | 1 | A data access is made this cycle |
| acc_offset | input | 32 | Offset of the access |
| abs_mode | input | 1 | Use `abs_seg` and skip selection |
| abs_seg | input | 16 | Segment value for absolute access |
| lin_addr | output | 33 | Linear address (combinational) |
| halt | output | 1 | Sticky fatal-error flag |

## Verification
The bench walks every legal prefix code with the stack-default bit also set. A wrong mapping or a stack bit that overrides a prefix shows up as the wrong segment in the address. It presents two different overrides at once: a design that let the last prefix win would return a non-zero base and leave `halt` low. It also presents the same case under absolute mode, where a design that checked overrides first would halt wrongly. Further tests cover:

- a prefix arriving in the same cycle as the end-of-instruction clear, which a design with the clear winning would lose;
- an access made in the same cycle as a prefix;
- the all-ones segment and offset, which catches a 32-bit wrap;
- illegal codes 6 and 7.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_COUNT = 6;
  localparam int CODE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_code_e;
endpackage

// File: rtl/seg_mode_track.sv
module seg_mode_track
  import seg_pkg::*;
#(
  parameter int NSEG = SEG_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_valid,
  input  logic [CODE_W-1:0] pfx_code,
  input  logic              stk_dflt_set,
  input  logic              insn_end,
  output logic [NSEG-1:0]   ovr_q,
  output logic              stk_q,
  output logic              bad_code
);
  logic [NSEG-1:0] hit;
  logic [NSEG-1:0] ovr_keep;
  logic            stk_keep;

  // One decode comparator per segment code.
  for (genvar i = 0; i < NSEG; i++) begin : g_hit
    assign hit[i] = pfx_valid && (pfx_code == CODE_W'(i));
  end

  assign bad_code = pfx_valid && (pfx_code >= CODE_W'(NSEG));

  // The clear applies to the instruction that is ending; new events survive it.
  assign ovr_keep = insn_end ? '0 : ovr_q;
  assign stk_keep = insn_end ? 1'b0 : stk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= '0;
      stk_q <= 1'b0;
    end else begin
      ovr_q <= ovr_keep | hit;
      stk_q <= stk_keep | stk_dflt_set;
    end
  end

  // R7: a clear with no new events leaves nothing behind.
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    insn_end && !pfx_valid && !stk_dflt_set |=> (ovr_q == '0) && !stk_q);

  // R4: a legal prefix on empty state records exactly one override.
  p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid && !bad_code && (ovr_q == '0) |=> $countones(ovr_q) == 1);

  // R9: an illegal code leaves the override set untouched.
  p_bad_no_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid && bad_code && !insn_end |=> $stable(ovr_q));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
#(
  parameter int NSEG  = SEG_COUNT,
  parameter int SEG_W = 16
) (
  input  logic [NSEG-1:0]             ovr,
  input  logic                        stk,
  input  logic                        abs_mode,
  input  logic [SEG_W-1:0]            abs_seg,
  input  logic [NSEG-1:0][SEG_W-1:0]  segs,
  output logic [SEG_W-1:0]            base,
  output logic                        multi
);
  logic [NSEG-1:0][SEG_W-1:0] masked;
  logic [SEG_W-1:0]           ovr_base;

  // Each register is gated by its own override bit; the OR is valid when one-hot.
  for (genvar i = 0; i < NSEG; i++) begin : g_mask
    assign masked[i] = segs[i] & {SEG_W{ovr[i]}};
  end

  always_comb begin
    ovr_base = '0;
    for (int i = 0; i < NSEG; i++) ovr_base = ovr_base | masked[i];
  end

  assign multi = ($countones(ovr) > 1);

  always_comb begin
    if (abs_mode)          base = abs_seg;
    else if (multi)        base = '0;
    else if (ovr != '0)    base = ovr_base;
    else if (stk)          base = segs[SEG_SS];
    else                   base = segs[SEG_DS];
  end
endmodule

// File: rtl/seg_lin_add.sv
module seg_lin_add #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 32,
  parameter int SHIFT = 4,
  parameter int LIN_W = 33
) (
  input  logic [SEG_W-1:0] base,
  input  logic [OFF_W-1:0] offset,
  output logic [LIN_W-1:0] lin
);
  function automatic logic [LIN_W-1:0] form_linear(
    input logic [SEG_W-1:0] s,
    input logic [OFF_W-1:0] o
  );
    return (LIN_W'(s) << SHIFT) + LIN_W'(o);
  endfunction

  assign lin = form_linear(base, offset);
endmodule

// File: rtl/seg_linear_former.sv
module seg_linear_former
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 32,
  parameter int SHIFT = 4,
  localparam int LIN_W = (((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_valid,
  input  logic [CODE_W-1:0] pfx_code,
  input  logic              stk_dflt_set,
  input  logic              insn_end,
  input  logic [SEG_W-1:0]  seg_es,
  input  logic [SEG_W-1:0]  seg_cs,
  input  logic [SEG_W-1:0]  seg_ss,
  input  logic [SEG_W-1:0]  seg_ds,
  input  logic [SEG_W-1:0]  seg_fs,
  input  logic [SEG_W-1:0]  seg_gs,
  input  logic              acc_valid,
  input  logic [OFF_W-1:0]  acc_offset,
  input  logic              abs_mode,
  input  logic [SEG_W-1:0]  abs_seg,
  output logic [LIN_W-1:0]  lin_addr,
  output logic              halt
);
  logic [SEG_COUNT-1:0]            ovr_q;
  logic                            stk_q;
  logic                            bad_code;
  logic [SEG_COUNT-1:0][SEG_W-1:0] segs;
  logic [SEG_W-1:0]                base;
  logic                            multi;
  logic                            multi_err;
  logic                            halt_q;

  // Index order follows the prefix code.
  assign segs[SEG_ES] = seg_es;
  assign segs[SEG_CS] = seg_cs;
  assign segs[SEG_SS] = seg_ss;
  assign segs[SEG_DS] = seg_ds;
  assign segs[SEG_FS] = seg_fs;
  assign segs[SEG_GS] = seg_gs;

  seg_mode_track #(.NSEG(SEG_COUNT)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .pfx_valid    (pfx_valid),
    .pfx_code     (pfx_code),
    .stk_dflt_set (stk_dflt_set),
    .insn_end     (insn_end),
    .ovr_q        (ovr_q),
    .stk_q        (stk_q),
    .bad_code     (bad_code)
  );

  seg_select #(.NSEG(SEG_COUNT), .SEG_W(SEG_W)) u_select (
    .ovr      (ovr_q),
    .stk      (stk_q),
    .abs_mode (abs_mode),
    .abs_seg  (abs_seg),
    .segs     (segs),
    .base     (base),
    .multi    (multi)
  );

  seg_lin_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .LIN_W(LIN_W)) u_add (
    .base   (base),
    .offset (acc_offset),
    .lin    (lin_addr)
  );

  // A conflict only matters when an access actually depends on selection.
  assign multi_err = acc_valid && !abs_mode && multi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_q | multi_err | bad_code;
  end

  assign halt = halt_q;

  // R10: once raised, the flag holds until reset.
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R9: an illegal prefix code is fatal.
  p_bad_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid && (pfx_code > CODE_W'(SEG_GS)) |=> halt);

  // R5: conflicting overrides at a selected access halt the block.
  p_multi_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !abs_mode && ($countones(ovr_q) > 1) |=> halt);

  // R5: and the base falls to zero.
  p_multi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !abs_mode && ($countones(ovr_q) > 1) |-> lin_addr == LIN_W'(acc_offset));

  // R8: absolute access uses the supplied segment.
  p_abs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && abs_mode |-> (lin_addr - LIN_W'(acc_offset)) == (LIN_W'(abs_seg) << SHIFT));

  // R3: the stack default picks SS when nothing overrides it.
  p_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !abs_mode && (ovr_q == '0) && stk_q |->
      (lin_addr - LIN_W'(acc_offset)) == (LIN_W'(seg_ss) << SHIFT));
endmodule

// File: tb/test_seg_linear_former.sv
module test_seg_linear_former;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pfx_valid, stk_dflt_set, insn_end, acc_valid, abs_mode;
  logic [2:0]  pfx_code;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds, seg_fs, seg_gs, abs_seg;
  logic [31:0] acc_offset;
  logic [32:0] lin_addr;
  logic        halt;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_linear_former i_seg_linear_former (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_code(pfx_code),
    .stk_dflt_set(stk_dflt_set), .insn_end(insn_end),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_fs(seg_fs), .seg_gs(seg_gs), .acc_valid(acc_valid),
    .acc_offset(acc_offset), .abs_mode(abs_mode), .abs_seg(abs_seg),
    .lin_addr(lin_addr), .halt(halt)
  );

  // Expected address: segment times sixteen plus offset, without truncation.
  function automatic logic [32:0] expect_lin(input logic [15:0] s, input logic [31:0] o);
    return {1'b0, o} + {13'd0, s, 4'd0};
  endfunction

  function automatic logic [15:0] seg_of(input int code);
    case (code)
      0: return seg_es;
      1: return seg_cs;
      2: return seg_ss;
      3: return seg_ds;
      4: return seg_fs;
      default: return seg_gs;
    endcase
  endfunction

  task automatic chk_lin(input string req, input logic [32:0] exp);
    n_cmp++;
    if (lin_addr !== exp) begin
      n_bad++;
      $display("FAIL %s lin_addr actual=%h expected=%h", req, lin_addr, exp);
    end
  endtask

  task automatic chk_halt(input string req, input logic exp);
    n_cmp++;
    if (halt !== exp) begin
      n_bad++;
      $display("FAIL %s halt actual=%b expected=%b", req, halt, exp);
    end
  endtask

  // Access checked mid-cycle, after the inputs settle.
  task automatic access(input logic [31:0] off, input logic ab, input logic [15:0] aseg);
    @(negedge clk);
    acc_valid = 1'b1; acc_offset = off; abs_mode = ab; abs_seg = aseg;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; abs_mode = 1'b0; pfx_valid = 1'b0;
    stk_dflt_set = 1'b0; insn_end = 1'b0;
  endtask

  task automatic prefix(input logic [2:0] code);
    @(negedge clk);
    acc_valid = 1'b0; pfx_valid = 1'b1; pfx_code = code;
    @(negedge clk);
    pfx_valid = 1'b0;
  endtask

  task automatic stack_dflt();
    @(negedge clk);
    stk_dflt_set = 1'b1;
    @(negedge clk);
    stk_dflt_set = 1'b0;
  endtask

  task automatic end_insn();
    @(negedge clk);
    acc_valid = 1'b0; insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pfx_valid = 1'b0; pfx_code = 3'd0; stk_dflt_set = 1'b0; insn_end = 1'b0;
    acc_valid = 1'b0; abs_mode = 1'b0; abs_seg = 16'h0; acc_offset = 32'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1 chk_halt("R1", 1'b0);
    access(32'h0000_1234, 1'b0, 16'h0);
    chk_lin("R1", expect_lin(seg_ds, 32'h0000_1234));
    idle();
  endtask

  task automatic t_default();
    access(32'h0000_0000, 1'b0, 16'h0); chk_lin("R2", expect_lin(seg_ds, 32'h0));
    access(32'hABCD_0010, 1'b0, 16'h0); chk_lin("R2", expect_lin(seg_ds, 32'hABCD_0010));
    idle();
  endtask

  task automatic t_stack();
    stack_dflt();
    access(32'h0000_0100, 1'b0, 16'h0); chk_lin("R3", expect_lin(seg_ss, 32'h100));
    end_insn();
    access(32'h0000_0100, 1'b0, 16'h0); chk_lin("R7 stack cleared", expect_lin(seg_ds, 32'h100));
    idle();
  endtask

  task automatic t_single();
    for (int c = 0; c < 6; c++) begin
      end_insn();
      stack_dflt();
      prefix(3'(c));
      access(32'h0000_0042, 1'b0, 16'h0);
      chk_lin($sformatf("R4 code %0d", c), expect_lin(seg_of(c), 32'h42));
    end
    end_insn();
    // R11: prefix and access in one cycle: the access sees the older state.
    @(negedge clk);
    pfx_valid = 1'b1; pfx_code = 3'd5; acc_valid = 1'b1; acc_offset = 32'h7; abs_mode = 1'b0;
    #1 chk_lin("R11 same-cycle access", expect_lin(seg_ds, 32'h7));
    @(negedge clk);
    pfx_valid = 1'b0;
    #1 chk_lin("R11 next cycle", expect_lin(seg_gs, 32'h7));
    end_insn();
    chk_halt("R4 no halt", 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    acc_valid = 1'b0; insn_end = 1'b1; pfx_valid = 1'b1; pfx_code = 3'd4;
    @(negedge clk);
    insn_end = 1'b0; pfx_valid = 1'b0;
    access(32'h10, 1'b0, 16'h0); chk_lin("R7 prefix kept", expect_lin(seg_fs, 32'h10));
    end_insn();
  endtask

  task automatic t_wide();
    seg_ds = 16'hFFFF;
    access(32'hFFFF_FFFF, 1'b0, 16'h0);
    chk_lin("R6 no wrap", 33'h1_000F_FFEF);
    seg_ds = 16'h4444;
    access(32'h0000_0005, 1'b0, 16'h0);
    chk_lin("R6", 33'h0_0004_4445);
    idle();
  endtask

  task automatic t_abs_and_multi();
    prefix(3'd0);
    prefix(3'd1);
    access(32'h20, 1'b1, 16'h9000);
    chk_lin("R8 abs", expect_lin(16'h9000, 32'h20));
    idle();
    #1 chk_halt("R8 no halt", 1'b0);
    access(32'h0000_0333, 1'b0, 16'h0);
    chk_lin("R5 zero base", 33'h333);
    idle();
    #1 chk_halt("R5 halt", 1'b1);
    end_insn();
    access(32'h1, 1'b0, 16'h0);
    idle();
    #1 chk_halt("R10 sticky", 1'b1);
  endtask

  task automatic t_illegal();
    do_reset();
    prefix(3'd6);
    #1 chk_halt("R9 code 6", 1'b1);
    access(32'h50, 1'b0, 16'h0);
    chk_lin("R9 no override", expect_lin(seg_ds, 32'h50));
    idle();
    do_reset();
    #1 chk_halt("R10 reset clears", 1'b0);
    prefix(3'd7);
    #1 chk_halt("R9 code 7", 1'b1);
    idle();
  endtask

  initial begin
    seg_es = 16'h1111; seg_cs = 16'h2222; seg_ss = 16'h3333;
    seg_ds = 16'h4444; seg_fs = 16'h5555; seg_gs = 16'h6666;
    rst_n = 1'b0;
    t_reset();
    t_default();
    t_stack();
    t_single();
    t_same_cycle();
    t_wide();
    t_abs_and_multi();
    t_illegal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule